// File: doc/BRIEF.md
# Pipelined Slave Bus Cycle Tracker

This block is a clocked state machine for a slave that listens to a bus driven by a master. It follows every bus cycle from the address strobe to the ready that ends it. It also tells a plain cycle, which drops back to idle, from an overlapped one, in which the master issues the next address while the current cycle is still being acknowledged. Downstream logic reads the current phase and three one-clock event pulses: cycle start, cycle end and pipelined start. These pulses can steer a data path that is not part of this block.

Both bus strobes are active-low and are sampled only on the rising clock edge. When the machine waits for ready, it samples ready and the address strobe together. If both are active, it moves through a one-clock pipeline phase and then returns to the ready-sampling phase. The new cycle therefore begins without passing through idle, and a run of overlapped cycles alternates between just those two phases.

Top module: `bus_cycle_tracker`

## Requirements
- R1: A synchronous active-high reset puts the phase at idle (code 0) and clears all three pulses at the next rising edge.
- R2: In idle, an address strobe sampled low while the select input is high moves the phase to request (code 1) and raises the cycle-start pulse for one clock. An address strobe sampled low while select is low is ignored: the phase stays idle and no pulse appears.
- R3: The request phase always lasts one clock and is followed by the ready-sample phase (code 2), whatever the inputs are.
- R4: In the ready-sample phase, if ready is sampled low and no qualified address strobe (address strobe low with select high) is seen, the phase goes to idle and the cycle-end pulse is raised for one clock.
- R5: In the ready-sample phase, if ready and a qualified address strobe are both sampled low, the phase goes to pipeline (code 3), and the cycle-end and pipelined-start pulses are raised together for one clock.
- R6: The pipeline phase always lasts exactly one clock and is followed by the ready-sample phase, whatever the inputs are.
- R7: While ready is sampled high in the ready-sample phase, the phase holds for any number of wait clocks, the address strobe is ignored and no pulse is raised.
- R8: Back-to-back overlapped cycles alternate only between ready-sample and pipeline, never visiting idle, with one pipelined-start pulse per pass.
- R9: Each pulse is high in the same clock in which the phase output shows the phase entered by that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adsN | input | 1 | Address strobe from the master, active low |
| rdyN | input | 1 | Bus ready, active low |
| sel | input | 1 | Chip-select qualifier, active high |
| busState | output | 2 | Current phase: 0 idle, 1 request, 2 ready-sample, 3 pipeline |
| cycStart | output | 1 | One-clock pulse on entry to request |
| cycEnd | output | 1 | One-clock pulse when ready is accepted |
| pipeStart | output | 1 | One-clock pulse on entry to pipeline |

## Verification
The bench builds the block with the default setting, in which select must also be high for an overlapped cycle. Under that setting, an address strobe seen during ready with select low must end the cycle in idle rather than in pipeline. The mixed sequences take in wait runs of several lengths, inputs toggled during the fixed one-clock phases, chains of three overlapped cycles, and a reset in the middle of a cycle. Each of these is compared clock by clock against a behavioural model.

// File: rtl/btk_pkg.sv
package btk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RDY  = 2'd2,
    ST_PIPE = 2'd3
  } busPhase_t;

  typedef struct packed {
    logic startHit;
    logic endHit;
    logic pipeHit;
  } ctlEvents_t;

endpackage

// File: rtl/btk_ctrl.sv
module btk_ctrl
  import btk_pkg::*;
#(
  parameter bit PIPE_NEEDS_SEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adsN,
  input  logic       rdyN,
  input  logic       sel,
  output busPhase_t  phase,
  output ctlEvents_t evt
);

  busPhase_t phaseNext;
  logic      adsHit;
  logic      adsPipe;

  assign adsHit = !adsN && sel;

  generate
    if (PIPE_NEEDS_SEL) begin : g_pipeQual
      assign adsPipe = adsHit;
    end else begin : g_pipeRaw
      assign adsPipe = !adsN;
    end
  endgenerate

  always_comb begin
    phaseNext = phase;
    evt       = '0;
    case (phase)
      ST_IDLE: begin
        if (adsHit) begin
          phaseNext    = ST_REQ;
          evt.startHit = 1'b1;
        end
      end
      ST_REQ: phaseNext = ST_RDY;
      ST_RDY: begin
        if (!rdyN) begin
          evt.endHit = 1'b1;
          if (adsPipe) begin
            phaseNext   = ST_PIPE;
            evt.pipeHit = 1'b1;
          end else begin
            phaseNext = ST_IDLE;
          end
        end
      end
      ST_PIPE: phaseNext = ST_RDY;
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_IDLE;
    else     phase <= phaseNext;
  end

  // R3: request lasts one clock
  p_req_next_r3: assert property (@(posedge clk) disable iff (rst)
    phase == ST_REQ |=> phase == ST_RDY);

  // R6: pipeline lasts one clock
  p_pipe_next_r6: assert property (@(posedge clk) disable iff (rst)
    phase == ST_PIPE |=> phase == ST_RDY);

  // R7: wait states hold
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RDY && rdyN) |=> phase == ST_RDY);

  // R4: plain end goes idle
  p_end_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RDY && !rdyN && !adsPipe) |=> phase == ST_IDLE);

  // R5: overlapped end goes to pipeline
  p_pipe_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RDY && !rdyN && adsPipe) |=> phase == ST_PIPE);

  // R2: unqualified strobe ignored in idle
  p_idle_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_IDLE && (adsN || !sel)) |=> phase == ST_IDLE);

endmodule

// File: rtl/btk_datapath.sv
module btk_datapath
  import btk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctlEvents_t evt,
  input  busPhase_t  phase,
  output logic       cycStart,
  output logic       cycEnd,
  output logic       pipeStart
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycStart  <= 1'b0;
      cycEnd    <= 1'b0;
      pipeStart <= 1'b0;
    end else begin
      cycStart  <= evt.startHit;
      cycEnd    <= evt.endHit;
      pipeStart <= evt.pipeHit;
    end
  end

  // R9: start pulse lines up with request phase
  p_start_align_r9: assert property (@(posedge clk) disable iff (rst)
    cycStart |-> phase == ST_REQ);

  // R9: end pulse lines up with idle or pipeline
  p_end_align_r9: assert property (@(posedge clk) disable iff (rst)
    cycEnd |-> (phase == ST_IDLE || phase == ST_PIPE));

  // R5: pipelined start always carries an end
  p_pipe_with_end_r5: assert property (@(posedge clk) disable iff (rst)
    pipeStart |-> (cycEnd && phase == ST_PIPE));

  // R8: pipelined start never repeats on the next clock
  p_pipe_gap_r8: assert property (@(posedge clk) disable iff (rst)
    pipeStart |=> !pipeStart);

endmodule

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker
  import btk_pkg::*;
#(
  parameter bit PIPE_NEEDS_SEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adsN,
  input  logic       rdyN,
  input  logic       sel,
  output logic [1:0] busState,
  output logic       cycStart,
  output logic       cycEnd,
  output logic       pipeStart
);

  busPhase_t  phase;
  ctlEvents_t evt;

  btk_ctrl #(.PIPE_NEEDS_SEL(PIPE_NEEDS_SEL)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .adsN  (adsN),
    .rdyN  (rdyN),
    .sel   (sel),
    .phase (phase),
    .evt   (evt)
  );

  btk_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .phase     (phase),
    .cycStart  (cycStart),
    .cycEnd    (cycEnd),
    .pipeStart (pipeStart)
  );

  assign busState = phase;

  // R1: reset clears phase and pulses
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (busState == 2'd0 && !cycStart && !cycEnd && !pipeStart));

endmodule

// File: tb/bus_cycle_tracker_bench.sv
module bus_cycle_tracker_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adsN = 1'b1;
  logic       rdyN = 1'b1;
  logic       sel = 1'b0;
  logic [1:0] busState;
  logic       cycStart, cycEnd, pipeStart;

  int checks = 0;
  int fails  = 0;
  int mState = 0;
  bit mStart = 0, mEnd = 0, mPipe = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_cycle_tracker u_bus_cycle_tracker (
    .clk(clk), .rst(rst), .adsN(adsN), .rdyN(rdyN), .sel(sel),
    .busState(busState), .cycStart(cycStart), .cycEnd(cycEnd),
    .pipeStart(pipeStart)
  );

  // Behavioural model: computes next phase and pulses from sampled inputs.
  task automatic modelStep(input bit r, input bit a, input bit y, input bit s);
    int n;
    n = mState;
    mStart = 0; mEnd = 0; mPipe = 0;
    if (r) begin
      n = 0;
    end else begin
      if (mState == 0) begin
        if (!a && s) begin n = 1; mStart = 1; end
      end else if (mState == 1) begin
        n = 2;
      end else if (mState == 2) begin
        if (!y) begin
          mEnd = 1;
          if (!a && s) begin n = 3; mPipe = 1; end
          else n = 0;
        end
      end else begin
        n = 2;
      end
    end
    mState = n;
  endtask

  // Drive one clock of inputs, then compare after the edge.
  task automatic cyc(input bit r, input bit a, input bit y, input bit s, input string tag);
    rst = r; adsN = a; rdyN = y; sel = s;
    modelStep(r, a, y, s);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (busState !== mState[1:0] || cycStart !== mStart ||
        cycEnd !== mEnd || pipeStart !== mPipe) begin
      fails++;
      $display("FAIL %s: state=%0d start=%0b end=%0b pipe=%0b expected state=%0d start=%0b end=%0b pipe=%0b",
               tag, busState, cycStart, cycEnd, pipeStart, mState, mStart, mEnd, mPipe);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 1, 0, "R1");
    cyc(1, 0, 0, 1, "R1");
    // R2: unqualified strobe ignored in idle
    cyc(0, 0, 1, 0, "R2");
    cyc(0, 0, 0, 0, "R2");
    cyc(0, 1, 1, 1, "R2");
    // non-pipelined cycle, no wait
    cyc(0, 0, 1, 1, "R2");
    cyc(0, 0, 0, 1, "R3");
    cyc(0, 1, 0, 1, "R4");
    cyc(0, 1, 1, 0, "R9");
    // wait states with strobe toggling
    cyc(0, 0, 1, 1, "R2");
    cyc(0, 1, 1, 1, "R3");
    for (int i = 0; i < 4; i++) cyc(0, i[0], 1, 1, "R7");
    // ready with unqualified strobe ends as plain cycle
    cyc(0, 0, 0, 0, "R4");
    // pipelined chain of three
    cyc(0, 0, 1, 1, "R2");
    cyc(0, 1, 1, 1, "R3");
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 1, "R8");
    cyc(0, 1, 1, 0, "R6");
    cyc(0, 1, 1, 1, "R7");
    cyc(0, 0, 0, 1, "R8");
    cyc(0, 1, 0, 1, "R6");
    cyc(0, 1, 0, 1, "R4");
    // pipeline after a wait run
    cyc(0, 0, 1, 1, "R2");
    cyc(0, 1, 0, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 1, "R6");
    // reset in the middle of a cycle
    cyc(1, 0, 0, 1, "R1");
    cyc(0, 1, 1, 1, "R1");
    // mixed run
    for (int i = 0; i < 40; i++)
      cyc(0, (i % 3) == 0, (i % 4) == 1, (i % 5) != 2, "R9");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule